// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the processor-side half of maskable interrupt handling in a small controller core. It keeps one request bit per interrupt source and the processor flag word: a global enable bit, a debug bit, a stack-select bit and a processor priority level field. When the core reports an instruction boundary, or a suspend point inside a long string or multiply-accumulate instruction, the block picks the best pending request and accepts it. It also accepts a software interrupt instruction at an instruction boundary.

Once a request is accepted the block runs its fixed entry order. It issues an acknowledge read of address 0, snapshots the flag word, and clears the enable, debug and stack-select bits. It then pushes the snapshot and the program counter through a write port with a pre-decrementing stack pointer, and loads the new priority level. Finally it announces the vector number for one cycle, at the point where the handler's first fetch may start. Each bus access waits for a ready handshake.

Flag word layout: bit 0 is the global enable, bit 1 is debug and bit 2 is stack-select (1 selects the user stack pointer). The priority level sits in bits [IPL_LSB+LVL_W-1:IPL_LSB], which is [14:12] by default.

Top module: `int_entry_seq`

## Requirements
- R1: After reset the flag word is 0, all request bits are 0, busy, bus_rd, bus_we and vec_valid are 0, and the interrupt stack pointer is ISP_RST and the user one USP_RST.
- R2: A high src_req bit sets that source's request bit on the next edge. A software write (req_wr) with req_wr_val=0 clears the indexed bit, and one with req_wr_val=1 leaves it unchanged. A hardware set wins over any clear in the same cycle.
- R3: A hardware request is accepted only in an idle cycle with insn_done or insn_susp high, global enable 1, and its level strictly above the current priority level. Otherwise the request stays pending.
- R4: Among pending sources the highest level wins, and equal levels go to the lowest source index. The vector number of hardware source i is i.
- R5: The accepted source's request bit is cleared on the accepting edge, and busy is high from the next cycle.
- R6: After acceptance the bus order is fixed: one read of address 0, then the flag push, then the program counter push. Each access holds its address and data until the cycle in which bus_rdy is high, and reads and writes never overlap.
- R7: The pushed flag word equals the flag word as it stood in the accepting cycle. The pushed program counter equals pc_in in the accepting cycle.
- R8: Entry clears the enable and debug bits. It clears stack-select as well, except for a software interrupt numbered SWI_KEEP_MIN (32) or above, which keeps it.
- R9: Each push writes at the selected stack pointer minus 1 and then leaves that pointer decremented. The selection follows stack-select after it has been cleared or kept, so the flag word goes to SP-1 and the program counter to SP-2.
- R10: The final entry step loads the accepted level into the priority field. A software interrupt leaves the priority field unchanged.
- R11: vec_valid is high for exactly one cycle, carries vec_num, and is the last cycle of busy. Busy then falls.
- R12: While busy, and in an accepting cycle, acceptance points, software interrupts and flag writes (flg_wr) are ignored. Request bits still latch while busy and are served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Per-source request strobes |
| src_lvl | input | NSRC*LVL_W | Per-source request levels, source i in slice i |
| req_wr | input | 1 | Software write to one request bit |
| req_wr_idx | input | IDX_W | Index of the written request bit |
| req_wr_val | input | 1 | Written value (only 0 has an effect) |
| req_pend | output | NSRC | Current request bits |
| flg_wr | input | 1 | Software write of the flag word |
| flg_wr_data | input | FLG_W | Flag word value to write |
| flg_out | output | FLG_W | Current flag word |
| insn_done | input | 1 | Instruction boundary strobe |
| insn_susp | input | 1 | Suspend point inside a long instruction |
| swi_valid | input | 1 | Software interrupt instruction at this boundary |
| swi_num | input | NUM_W | Software interrupt number |
| pc_in | input | DATA_W | Program counter to save |
| busy | output | 1 | Entry sequence in progress |
| bus_rd | output | 1 | Acknowledge read request |
| bus_we | output | 1 | Stack write request |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Stack write data |
| bus_rdy | input | 1 | Bus ready, completes the current access |
| vec_valid | output | 1 | Handler may be entered, one cycle |
| vec_num | output | NUM_W | Accepted vector number |

## Verification
Request bits and flag writes show on the outputs one edge after their strobe. An acceptance edge raises busy and drives the acknowledge read in the following cycle. The two pushes each complete on the edge where bus_rdy is high, and the priority load and vec_valid follow in two further single cycles. The bench runs a behavioural model that advances on the same edge as the design and compares every output half a period later, at the falling edge. Stalls on bus_rdy therefore shift every later step by exactly the stalled cycles. Explicit checks of the delivered vector number and the pending bits are made only after busy has fallen.

// File: rtl/ies_pkg.sv
package ies_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACK,
      ST_SAVE,
      ST_CLRF,
      ST_PUSHF,
      ST_PUSHPC,
      ST_IPL,
      ST_DONE
   } ies_state_e;

   localparam int FB_IEN  = 0;
   localparam int FB_DBG  = 1;
   localparam int FB_USEL = 2;

endpackage

// File: rtl/ies_req_bank.sv
module ies_req_bank #(
   parameter int NSRC = 8,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  hw_set,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic             sw_val,
   input  logic             acc_clr,
   input  logic [IDX_W-1:0] acc_idx,
   output logic [NSRC-1:0]  pend
);

   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      logic clr_g;
      assign clr_g = (sw_we && !sw_val && sw_idx == IDX_W'(g)) ||
                     (acc_clr && acc_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[g] <= 1'b0;
         else        pend[g] <= hw_set[g] | (pend[g] & ~clr_g);
      end
   end

endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter #(
   parameter int NSRC  = 8,
   parameter int LVL_W = 3,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]       pend,
   input  logic [NSRC*LVL_W-1:0] lvl_flat,
   output logic                  win_any,
   output logic [IDX_W-1:0]      win_idx,
   output logic [LVL_W-1:0]      win_lvl
);

   always_comb begin
      win_any = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      // scan downwards with >= so the lowest index wins a tie
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i] && (!win_any || lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
            win_any = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl_flat[i*LVL_W +: LVL_W];
         end
      end
   end

endmodule

// File: rtl/ies_stack.sv
module ies_stack #(
   parameter int          ADDR_W  = 16,
   parameter int unsigned ISP_RST = 32'h0400,
   parameter int unsigned USP_RST = 32'h0800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_usp,
   input  logic              dec,
   output logic [ADDR_W-1:0] sp_cur
);

   logic [ADDR_W-1:0] sp_q [2];

   for (genvar g = 0; g < 2; g++) begin : g_sp
      localparam logic [ADDR_W-1:0] RST_V = (g == 0) ? ADDR_W'(ISP_RST) : ADDR_W'(USP_RST);
      logic sel_g;
      assign sel_g = (g == 1) ? use_usp : !use_usp;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            sp_q[g] <= RST_V;
         else if (dec && sel_g) sp_q[g] <= sp_q[g] - 1'b1;
      end
   end

   assign sp_cur = use_usp ? sp_q[1] : sp_q[0];

endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
   import ies_pkg::*;
#(
   parameter int          NSRC         = 8,
   parameter int          LVL_W        = 3,
   parameter int          ADDR_W       = 16,
   parameter int          DATA_W       = 16,
   parameter int          FLG_W        = 16,
   parameter int          IPL_LSB      = 12,
   parameter int          NUM_W        = 6,
   parameter int          SWI_KEEP_MIN = 32,
   parameter int unsigned ISP_RST      = 32'h0400,
   parameter int unsigned USP_RST      = 32'h0800,
   localparam int         IDX_W        = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        src_req,
   input  logic [NSRC*LVL_W-1:0]  src_lvl,
   input  logic                   req_wr,
   input  logic [IDX_W-1:0]       req_wr_idx,
   input  logic                   req_wr_val,
   output logic [NSRC-1:0]        req_pend,
   input  logic                   flg_wr,
   input  logic [FLG_W-1:0]       flg_wr_data,
   output logic [FLG_W-1:0]       flg_out,
   input  logic                   insn_done,
   input  logic                   insn_susp,
   input  logic                   swi_valid,
   input  logic [NUM_W-1:0]       swi_num,
   input  logic [DATA_W-1:0]      pc_in,
   output logic                   busy,
   output logic                   bus_rd,
   output logic                   bus_we,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [DATA_W-1:0]      bus_wdata,
   input  logic                   bus_rdy,
   output logic                   vec_valid,
   output logic [NUM_W-1:0]       vec_num
);

   if (NSRC < 2 || NSRC > (1 << NUM_W)) begin : g_bad_nsrc
      $error("NSRC must lie between 2 and 2**NUM_W");
   end
   if (IPL_LSB <= FB_USEL || IPL_LSB + LVL_W > FLG_W) begin : g_bad_ipl
      $error("priority field overlaps control bits or exceeds the flag word");
   end
   if (FLG_W > DATA_W) begin : g_bad_flg
      $error("flag word must fit one stack word");
   end
   if (SWI_KEEP_MIN >= (1 << NUM_W)) begin : g_bad_swi
      $error("SWI_KEEP_MIN must be a representable vector number");
   end

   ies_state_e          state;
   logic [FLG_W-1:0]    flg;
   logic [FLG_W-1:0]    tmp;
   logic [DATA_W-1:0]   pc_lat;
   logic [NUM_W-1:0]    num_lat;
   logic [LVL_W-1:0]    lvl_lat;
   logic                keep_u;

   logic                win_any;
   logic [IDX_W-1:0]    win_idx;
   logic [LVL_W-1:0]    win_lvl;
   logic [LVL_W-1:0]    cur_ipl;
   logic                idle;
   logic                acc_swi;
   logic                acc_hw;
   logic                accept;
   logic [ADDR_W-1:0]   sp_cur;
   logic                push_go;

   assign idle    = (state == ST_IDLE);
   assign cur_ipl = flg[IPL_LSB +: LVL_W];
   assign acc_swi = idle && insn_done && swi_valid;
   assign acc_hw  = idle && !acc_swi && (insn_done || insn_susp) &&
                    flg[FB_IEN] && win_any && (win_lvl > cur_ipl);
   assign accept  = acc_swi || acc_hw;

   ies_req_bank #(.NSRC(NSRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (src_req),
      .sw_we   (req_wr),
      .sw_idx  (req_wr_idx),
      .sw_val  (req_wr_val),
      .acc_clr (acc_hw),
      .acc_idx (win_idx),
      .pend    (req_pend)
   );

   ies_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
      .pend     (req_pend),
      .lvl_flat (src_lvl),
      .win_any  (win_any),
      .win_idx  (win_idx),
      .win_lvl  (win_lvl)
   );

   ies_stack #(.ADDR_W(ADDR_W), .ISP_RST(ISP_RST), .USP_RST(USP_RST)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .use_usp (flg[FB_USEL]),
      .dec     (push_go),
      .sp_cur  (sp_cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         flg     <= '0;
         tmp     <= '0;
         pc_lat  <= '0;
         num_lat <= '0;
         lvl_lat <= '0;
         keep_u  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state   <= ST_ACK;
                  pc_lat  <= pc_in;
                  num_lat <= acc_swi ? swi_num : NUM_W'(win_idx);
                  lvl_lat <= acc_swi ? cur_ipl : win_lvl;
                  keep_u  <= acc_swi && (swi_num >= NUM_W'(SWI_KEEP_MIN));
               end else if (flg_wr) begin
                  flg <= flg_wr_data;
               end
            end
            ST_ACK:    if (bus_rdy) state <= ST_SAVE;
            ST_SAVE: begin
               tmp   <= flg;
               state <= ST_CLRF;
            end
            ST_CLRF: begin
               flg[FB_IEN] <= 1'b0;
               flg[FB_DBG] <= 1'b0;
               if (!keep_u) flg[FB_USEL] <= 1'b0;
               state <= ST_PUSHF;
            end
            ST_PUSHF:  if (bus_rdy) state <= ST_PUSHPC;
            ST_PUSHPC: if (bus_rdy) state <= ST_IPL;
            ST_IPL: begin
               flg[IPL_LSB +: LVL_W] <= lvl_lat;
               state <= ST_DONE;
            end
            ST_DONE:   state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign bus_rd    = (state == ST_ACK);
   assign bus_we    = (state == ST_PUSHF) || (state == ST_PUSHPC);
   assign push_go   = bus_we && bus_rdy;
   assign bus_addr  = bus_we ? (sp_cur - 1'b1) : '0;
   assign bus_wdata = (state == ST_PUSHF) ? DATA_W'(tmp) : pc_lat;
   assign busy      = !idle;
   assign vec_valid = (state == ST_DONE);
   assign vec_num   = num_lat;
   assign flg_out   = flg;

endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int FLG_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              bus_rd,
   input logic              bus_we,
   input logic              bus_rdy,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              vec_valid,
   input logic [FLG_W-1:0]  flg_out
);

   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_we));

   a_r6_ack_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (bus_addr == '0));

   a_r6_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_rdy) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));

   a_r11_vec_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> busy);

   a_r11_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> (!vec_valid && !busy));

   a_r8_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (!flg_out[0] && !flg_out[1]));

endmodule

bind int_entry_seq ies_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .FLG_W  (FLG_W)
) u_ies_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .bus_rd    (bus_rd),
   .bus_we    (bus_we),
   .bus_rdy   (bus_rdy),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .vec_valid (vec_valid),
   .flg_out   (flg_out)
);

// File: tb/int_entry_seq_test.sv
`timescale 1ns/1ps
module int_entry_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_req = '0;
   logic [23:0] src_lvl;
   logic        req_wr = 1'b0;
   logic [2:0]  req_wr_idx = '0;
   logic        req_wr_val = 1'b0;
   logic [7:0]  req_pend;
   logic        flg_wr = 1'b0;
   logic [15:0] flg_wr_data = '0;
   logic [15:0] flg_out;
   logic        insn_done = 1'b0;
   logic        insn_susp = 1'b0;
   logic        swi_valid = 1'b0;
   logic [5:0]  swi_num = '0;
   logic [15:0] pc_in = 16'h1234;
   logic        busy, bus_rd, bus_we, vec_valid;
   logic [15:0] bus_addr, bus_wdata;
   logic        bus_rdy = 1'b1;
   logic [5:0]  vec_num;

   int checks = 0;
   int errors = 0;
   int lv [8] = '{1, 5, 3, 2, 5, 7, 0, 4};

   always #2.5 clk = ~clk;

   for (genvar g = 0; g < 8; g++) begin : g_lvl
      assign src_lvl[g*3 +: 3] = 3'(lv[g]);
   end

   int_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_lvl(src_lvl),
      .req_wr(req_wr), .req_wr_idx(req_wr_idx), .req_wr_val(req_wr_val),
      .req_pend(req_pend), .flg_wr(flg_wr), .flg_wr_data(flg_wr_data),
      .flg_out(flg_out), .insn_done(insn_done), .insn_susp(insn_susp),
      .swi_valid(swi_valid), .swi_num(swi_num), .pc_in(pc_in),
      .busy(busy), .bus_rd(bus_rd), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .vec_valid(vec_valid),
      .vec_num(vec_num)
   );

   // behavioural reference model
   int          mstep;
   logic [15:0] mflg, mtmp, mpc, misp, musp;
   logic [7:0]  mreq, nreq;
   int          mnum, mlvl, bi, bl;
   bit          mkeep;

   always @(posedge clk) begin
      if (!rst_n) begin
         mstep = 0; mflg = '0; mtmp = '0; mpc = '0; mreq = '0;
         misp = 16'h0400; musp = 16'h0800; mnum = 0; mlvl = 0; mkeep = 0;
      end else begin
         nreq = mreq;
         if (req_wr && !req_wr_val) nreq[req_wr_idx] = 1'b0;
         case (mstep)
            0: begin
               bi = -1; bl = -1;
               for (int i = 0; i < 8; i++)
                  if (mreq[i] && lv[i] > bl) begin bl = lv[i]; bi = i; end
               if (insn_done && swi_valid) begin
                  mstep = 1; mpc = pc_in; mnum = int'(swi_num);
                  mlvl = int'(mflg[14:12]); mkeep = (swi_num >= 6'd32);
               end else if ((insn_done || insn_susp) && mflg[0] && bi >= 0 &&
                            bl > int'(mflg[14:12])) begin
                  mstep = 1; mpc = pc_in; mnum = bi; mlvl = bl; mkeep = 0;
                  nreq[bi] = 1'b0;
               end else if (flg_wr) mflg = flg_wr_data;
            end
            1: if (bus_rdy) mstep = 2;
            2: begin mtmp = mflg; mstep = 3; end
            3: begin
               mflg[0] = 1'b0; mflg[1] = 1'b0;
               if (!mkeep) mflg[2] = 1'b0;
               mstep = 4;
            end
            4, 5: if (bus_rdy) begin
               if (mflg[2]) musp = musp - 1; else misp = misp - 1;
               mstep = mstep + 1;
            end
            6: begin mflg[14:12] = 3'(mlvl); mstep = 7; end
            default: mstep = 0;
         endcase
         mreq = nreq | src_req;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   bit cmp_en = 0;
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk("R11 busy", busy, mstep != 0);
         chk("R6 bus_rd", bus_rd, mstep == 1);
         chk("R6 bus_we", bus_we, mstep == 4 || mstep == 5);
         if (mstep == 1) chk("R6 ack address", bus_addr, 0);
         if (mstep == 4) begin
            chk("R9 flag push address", bus_addr, (mflg[2] ? musp : misp) - 16'd1);
            chk("R7 flag push data", bus_wdata, mtmp);
         end
         if (mstep == 5) begin
            chk("R9 pc push address", bus_addr, (mflg[2] ? musp : misp) - 16'd1);
            chk("R7 pc push data", bus_wdata, mpc);
         end
         chk("R11 vec_valid", vec_valid, mstep == 7);
         if (mstep == 7) chk("R11 vec_num", vec_num, mnum);
         chk("R8 R10 flag word", flg_out, mflg);
         chk("R2 R5 request bits", req_pend, mreq);
      end
   end

   int last_vec = -1;
   int vec_cnt = 0;
   always @(posedge clk) if (rst_n && vec_valid) begin
      last_vec <= int'(vec_num);
      vec_cnt  <= vec_cnt + 1;
   end

   // stall pattern for bus_rdy
   bit stall = 0;
   int scnt = 0;
   always @(negedge clk) begin
      scnt++;
      bus_rdy <= stall ? (scnt % 3 == 2) : 1'b1;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_flg(input logic [15:0] v);
      flg_wr = 1'b1; flg_wr_data = v; cyc(1); flg_wr = 1'b0;
   endtask

   task automatic raise(input logic [7:0] m);
      src_req = m; cyc(1); src_req = '0;
   endtask

   task automatic boundary(input bit susp);
      if (susp) insn_susp = 1'b1; else insn_done = 1'b1;
      cyc(1);
      insn_done = 1'b0; insn_susp = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 200 && busy; k++) cyc(1);
      cyc(1);
   endtask

   task automatic swi(input logic [5:0] n);
      swi_valid = 1'b1; swi_num = n; insn_done = 1'b1; cyc(1);
      swi_valid = 1'b0; insn_done = 1'b0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 flag word", flg_out, 0);
      chk("R1 request bits", req_pend, 0);
      chk("R1 vec_valid", vec_valid, 0);
      cmp_en = 1;

      // basic acceptance
      set_flg(16'h0001);
      raise(8'h04);
      chk("R2 bit set", req_pend[2], 1);
      pc_in = 16'hA5A0;
      boundary(0);
      wait_idle();
      chk("R3 accepted source", last_vec, 2);
      chk("R5 bit cleared", req_pend[2], 0);
      chk("R10 level loaded", flg_out, 16'h3000);

      // software write of 1 ignored, write of 0 clears
      raise(8'h40);
      req_wr = 1'b1; req_wr_idx = 3'd6; req_wr_val = 1'b1; cyc(1); req_wr = 1'b0;
      chk("R2 write one ignored", req_pend[6], 1);
      req_wr = 1'b1; req_wr_val = 1'b0; cyc(1); req_wr = 1'b0;
      chk("R2 write zero clears", req_pend[6], 0);

      // priority and ties, accepted at a suspend point
      raise(8'h1A);
      set_flg(16'h0001);
      pc_in = 16'h0102;
      boundary(1);
      wait_idle();
      chk("R4 tie to lowest index", last_vec, 1);
      set_flg(16'h0001);
      boundary(0);
      wait_idle();
      chk("R4 second of the tie", last_vec, 4);
      set_flg(16'h0001);
      boundary(0);
      wait_idle();
      chk("R4 remaining source", last_vec, 3);

      // level and enable gates
      set_flg(16'h3001);
      raise(8'h04);
      boundary(0);
      cyc(2);
      chk("R3 equal level not accepted", busy, 0);
      chk("R3 request kept", req_pend[2], 1);
      set_flg(16'h0000);
      boundary(0);
      cyc(2);
      chk("R3 disabled not accepted", busy, 0);
      set_flg(16'h0001);
      boundary(0);
      wait_idle();
      chk("R3 accepted once enabled", last_vec, 2);

      // software interrupts and stack-select
      set_flg(16'h0007);
      pc_in = 16'hBEEF;
      swi(6'd40);
      wait_idle();
      chk("R8 high swi keeps select", flg_out, 16'h0004);
      chk("R11 swi vector", last_vec, 40);
      set_flg(16'h2006);
      swi(6'd5);
      wait_idle();
      chk("R8 low swi clears select", flg_out, 16'h2000);
      chk("R10 swi keeps level", flg_out[14:12], 2);

      // stalls and requests while busy
      stall = 1;
      set_flg(16'h0001);
      raise(8'h80);
      boundary(0);
      cyc(1);
      src_req = 8'h20; insn_done = 1'b1; flg_wr = 1'b1; flg_wr_data = 16'hFFFF;
      cyc(2);
      src_req = '0; insn_done = 1'b0; flg_wr = 1'b0;
      wait_idle();
      chk("R12 busy accepted source", last_vec, 7);
      chk("R12 flag write ignored", flg_out, 16'h4000);
      chk("R12 request latched", req_pend[5], 1);
      set_flg(16'h0001);
      boundary(0);
      wait_idle();
      chk("R12 later served", last_vec, 5);
      stall = 0;
      cyc(4);
      chk("R11 vector count", vec_cnt, 9);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule